// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block is the host-side controller for a 12-bit successive-approximation converter that has a serial output and runs from a clock the host provides. It paces conversions by sending short active-low convert pulses at a programmable interval. It follows the converter's active-low busy line and generates the serial clock and a select line. The incoming bits are shifted, most significant first, into a parallel word. That word is presented sign-extended to 16 bits together with a one-cycle valid strobe.

Three read strategies are available:
- **After completion.** The whole word is fetched once busy has returned high.
- **Next conversion.** The whole word is fetched shortly after the next convert pulse, while the converter's previous result is still held.
- **Split.** Eight bits are fetched after completion and the remaining four early in the following conversion.

Late in each conversion the converter is sensitive to noise. The sequencer keeps every one of its outputs static from a fixed point after the convert pulse until busy rises, and it keeps the serial clock low whenever busy may rise. If the programmed clock rate is too slow for an early read to fit before that quiet point, a flag is raised and the whole word is fetched after completion instead.

Top module: `adc_read_sequencer`

## Requirements
- R1: After reset, `adc_conv_n` and `adc_cs_n` are 1, `adc_sclk` is 0, and `rd_valid`, `rd_word` and `early_slow` are 0.
- R2: A convert pulse holds `adc_conv_n` low for exactly CONV_LOW_CYC (default 3) cycles. A pulse is only issued when no conversion is outstanding and no serial transfer is active or scheduled.
- R3: While `run_en` is 1 and reads keep up, the distance between convert falling edges is max(`period_cyc`, MIN_PERIOD) cycles (default MIN_PERIOD 1250).
- R4: `adc_sclk` idles low. Each high and each low phase lasts max(`sclk_half`, 3) cycles. `adc_cs_n` is 0 whenever `adc_sclk` is 1, and returns to 1 between transfers.
- R5: Bits are taken from `adc_sdata` when `adc_sclk` falls, 12 per word, first bit into bit 11. `rd_word` holds bit 11 copied into bits 15:12. `rd_valid` is a single-cycle pulse, and at that moment `adc_cs_n` is 1.
- R6: With `strategy` 2'b00 or 2'b11, all 12 bits of conversion n are read after busy rises for conversion n, so n conversions give n words.
- R7: With `strategy` 2'b01 and a fast enough clock, the result of conversion n is read starting LEAD_CYC cycles after convert pulse n+1. A run of n conversions gives n-1 words.
- R8: With `strategy` 2'b10 and a fast enough clock, 8 bits are read after busy rises and the remaining 4 early in the next conversion. The word is valid only after the final 4 bits, so a run of n conversions gives n-1 words.
- R9: From QUIET_CYC (default 400) cycles after a convert falling edge until busy rises, none of `adc_conv_n`, `adc_sclk` and `adc_cs_n` changes. `adc_sclk` is 0 when busy rises, so no result is lost.
- R10: For strategies 2'b01 and 2'b10, `early_slow` is 1 exactly when LEAD_CYC + (2·b+1)·max(`sclk_half`,3) + 1 > QUIET_CYC, where b is 12 for 2'b01 and 4 for 2'b10. While it is 1, the full word is read after busy rises, giving n words for n conversions.
- R11: While `run_en` is 0 no convert pulse is issued, and a pending early read of an earlier run is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows periodic conversions |
| period_cyc | input | 16 | Requested conversion interval in cycles |
| sclk_half | input | 8 | Serial clock half period in cycles |
| strategy | input | 2 | Read strategy: 00/11 after, 01 next, 10 split |
| adc_busy_n | input | 1 | Converter busy, low while converting |
| adc_sdata | input | 1 | Converter serial data |
| adc_conv_n | output | 1 | Active-low convert pulse |
| adc_sclk | output | 1 | Generated serial clock |
| adc_cs_n | output | 1 | Active-low select |
| rd_word | output | 16 | Captured word, sign-extended |
| rd_valid | output | 1 | One-cycle strobe for a new word |
| early_slow | output | 1 | Early read does not fit before the quiet point |

## Verification
The hardest situation to reach is the split read that straddles two conversions. Half of the word must be in the assembly register when the next convert pulse fires, and the converter's output register must not be reloaded in between. Reaching it needs a converter model that reloads only if the serial clock is low when busy rises and that keeps its bit position across select toggles. The stimulus then runs back-to-back conversions with the split strategy at both a fast clock and a half period just past the fit limit. The model also counts every output change inside the quiet window and every result lost at busy rise, and the bench compares both counts against zero.

// File: rtl/srd_pkg.sv
package srd_pkg;
   typedef enum logic [1:0] {
      STRAT_AFTER = 2'b00,
      STRAT_NEXT  = 2'b01,
      STRAT_SPLIT = 2'b10,
      STRAT_ALT   = 2'b11
   } strat_e;

   typedef enum logic [1:0] {
      RD_IDLE = 2'b00,
      RD_LEAD = 2'b01,
      RD_HI   = 2'b10,
      RD_LO   = 2'b11
   } rd_state_e;
endpackage

// File: rtl/srd_pacer.sv
module srd_pacer #(
   parameter int PW          = 16,
   parameter int MIN_PERIOD  = 1250,
   parameter int CONV_LOW_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [PW-1:0] period,
   input  logic          ok,
   output logic          conv_n,
   output logic          fire
);
   localparam int LW = (CONV_LOW_CYC > 1) ? $clog2(CONV_LOW_CYC) : 1;
   localparam logic [PW-1:0] MINP = PW'(MIN_PERIOD);

   logic [PW-1:0] cnt;
   logic [LW-1:0] low_left;
   logic [PW-1:0] period_eff;

   assign period_eff = (period < MINP) ? MINP : period;
   assign fire = enable && ok && conv_n && (cnt >= period_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '1;
         conv_n   <= 1'b1;
         low_left <= '0;
      end else begin
         if (fire) begin
            cnt      <= PW'(1);
            conv_n   <= 1'b0;
            low_left <= LW'(CONV_LOW_CYC - 1);
         end else begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (!conv_n) begin
               if (low_left == '0) conv_n <= 1'b1;
               else                low_left <= low_left - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/srd_shift_reader.sv
module srd_shift_reader
   import srd_pkg::*;
#(
   parameter int NB = 12,
   parameter int HW = 8,
   parameter int CW = $clog2(NB + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          clear,
   input  logic [CW-1:0] nbits,
   input  logic [HW-1:0] half,
   input  logic          sdata,
   output logic          sclk,
   output logic          cs_n,
   output logic          busy,
   output logic          done,
   output logic [NB-1:0] acc
);
   rd_state_e     st;
   logic [HW-1:0] tmr;
   logic [HW-1:0] half_q;
   logic [CW-1:0] left;

   assign busy = (st != RD_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         tmr    <= '0;
         half_q <= '0;
         left   <= '0;
         sclk   <= 1'b0;
         cs_n   <= 1'b1;
         done   <= 1'b0;
         acc    <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            RD_IDLE: if (start) begin
               cs_n   <= 1'b0;
               st     <= RD_LEAD;
               tmr    <= half - 1'b1;
               half_q <= half;
               left   <= nbits;
               if (clear) acc <= '0;
            end
            RD_LEAD: if (tmr == '0) begin
               sclk <= 1'b1;
               st   <= RD_HI;
               tmr  <= half_q - 1'b1;
            end else tmr <= tmr - 1'b1;
            RD_HI: if (tmr == '0) begin
               sclk <= 1'b0;
               acc  <= {acc[NB-2:0], sdata};
               left <= left - 1'b1;
               st   <= RD_LO;
               tmr  <= half_q - 1'b1;
            end else tmr <= tmr - 1'b1;
            RD_LO: if (tmr == '0) begin
               if (left == '0) begin
                  cs_n <= 1'b1;
                  st   <= RD_IDLE;
                  done <= 1'b1;
               end else begin
                  sclk <= 1'b1;
                  st   <= RD_HI;
                  tmr  <= half_q - 1'b1;
               end
            end else tmr <= tmr - 1'b1;
            default: st <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_read_sequencer.sv
module adc_read_sequencer
   import srd_pkg::*;
#(
   parameter int NB           = 12,
   parameter int OUT_W        = 16,
   parameter int SIGN_EXT     = 1,
   parameter int SPLIT_FIRST  = 8,
   parameter int PW           = 16,
   parameter int HW           = 8,
   parameter int MIN_PERIOD   = 1250,
   parameter int CONV_LOW_CYC = 3,
   parameter int QUIET_CYC    = 400,
   parameter int LEAD_CYC     = 8,
   parameter int HALF_MIN     = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [PW-1:0]    period_cyc,
   input  logic [HW-1:0]    sclk_half,
   input  logic [1:0]       strategy,
   input  logic             adc_busy_n,
   input  logic             adc_sdata,
   output logic             adc_conv_n,
   output logic             adc_sclk,
   output logic             adc_cs_n,
   output logic [OUT_W-1:0] rd_word,
   output logic             rd_valid,
   output logic             early_slow
);
   localparam int CW = $clog2(NB + 1);
   localparam int LCW = $clog2(LEAD_CYC + 1);
   localparam int REST = NB - SPLIT_FIRST;

   if (OUT_W < NB) begin : g_bad_width
      $error("OUT_W must not be below NB");
   end
   if (SPLIT_FIRST < 1 || SPLIT_FIRST >= NB) begin : g_bad_split
      $error("SPLIT_FIRST must lie inside the word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CONV_LOW_CYC < 2 || LEAD_CYC < 2 || HALF_MIN < 2) begin : g_bad_timing
      $error("timing parameters too small");
   end

   // busy synchroniser: conv_act high while the converter works
   logic [SYNC_STAGES-1:0] bsync;
   logic conv_act, act_q, done_evt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bsync <= '0;
         act_q <= 1'b0;
      end else begin
         bsync <= {bsync[SYNC_STAGES-2:0], ~adc_busy_n};
         act_q <= conv_act;
      end
   end
   assign conv_act = bsync[SYNC_STAGES-1];
   assign done_evt = act_q & ~conv_act;

   // early-read fit test
   strat_e        strat;
   logic [HW-1:0] half_eff;
   int            early_bits, need;
   logic          early_mode, slow_now;
   assign strat      = strat_e'(strategy);
   assign half_eff   = (sclk_half < HW'(HALF_MIN)) ? HW'(HALF_MIN) : sclk_half;
   assign early_bits = (strat == STRAT_NEXT) ? NB : REST;
   assign need       = LEAD_CYC + (2 * early_bits + 1) * int'(half_eff) + 1;
   assign early_mode = (strat == STRAT_NEXT) || (strat == STRAT_SPLIT);
   assign slow_now   = early_mode && (need > QUIET_CYC);

   // scheduling state
   logic           in_conv, slow_q, pend_next, final_q;
   strat_e         mode_q;
   logic [CW-1:0]  pend_bits;
   logic [LCW-1:0] lead_cnt;
   logic           fire, ok;
   logic           rd_start, rd_clear, rd_final, rd_busy, rd_done;
   logic [CW-1:0]  rd_bits;
   logic [NB-1:0]  acc;
   logic [OUT_W-1:0] ext;

   assign ok = !in_conv && !rd_busy && (lead_cnt == '0);

   always_comb begin
      rd_start = 1'b0;
      rd_clear = 1'b0;
      rd_final = 1'b1;
      rd_bits  = CW'(NB);
      if (done_evt) begin
         if (slow_q || (mode_q != STRAT_NEXT && mode_q != STRAT_SPLIT)) begin
            rd_start = 1'b1;
            rd_clear = 1'b1;
         end else if (mode_q == STRAT_SPLIT) begin
            rd_start = 1'b1;
            rd_clear = 1'b1;
            rd_final = 1'b0;
            rd_bits  = CW'(SPLIT_FIRST);
         end
      end else if (lead_cnt == LCW'(1)) begin
         rd_start = 1'b1;
         rd_bits  = pend_bits;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_conv    <= 1'b0;
         slow_q     <= 1'b0;
         mode_q     <= STRAT_AFTER;
         pend_next  <= 1'b0;
         pend_bits  <= '0;
         lead_cnt   <= '0;
         final_q    <= 1'b0;
         early_slow <= 1'b0;
      end else begin
         early_slow <= slow_now;
         if (fire) begin
            in_conv <= 1'b1;
            mode_q  <= strat;
            slow_q  <= slow_now;
            if (pend_next) begin
               lead_cnt  <= LCW'(LEAD_CYC);
               pend_next <= 1'b0;
            end
         end else begin
            if (done_evt) begin
               in_conv <= 1'b0;
               if (!slow_q && mode_q == STRAT_NEXT) begin
                  pend_next <= run_en;
                  pend_bits <= CW'(NB);
               end else if (!slow_q && mode_q == STRAT_SPLIT) begin
                  pend_next <= run_en;
                  pend_bits <= CW'(REST);
               end
            end else if (!run_en) begin
               pend_next <= 1'b0;
            end
            if (lead_cnt != '0) lead_cnt <= lead_cnt - 1'b1;
         end
         if (rd_start) final_q <= rd_final;
      end
   end

   srd_pacer #(
      .PW(PW), .MIN_PERIOD(MIN_PERIOD), .CONV_LOW_CYC(CONV_LOW_CYC)
   ) u_pacer (
      .clk(clk), .rst_n(rst_n), .enable(run_en), .period(period_cyc),
      .ok(ok), .conv_n(adc_conv_n), .fire(fire)
   );

   srd_shift_reader #(.NB(NB), .HW(HW), .CW(CW)) u_reader (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .clear(rd_clear),
      .nbits(rd_bits), .half(half_eff), .sdata(adc_sdata),
      .sclk(adc_sclk), .cs_n(adc_cs_n), .busy(rd_busy), .done(rd_done),
      .acc(acc)
   );

   if (OUT_W == NB) begin : g_no_ext
      assign ext = acc;
   end else if (SIGN_EXT != 0) begin : g_sign
      assign ext = {{(OUT_W-NB){acc[NB-1]}}, acc};
   end else begin : g_zero
      assign ext = {{(OUT_W-NB){1'b0}}, acc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_word  <= '0;
      end else begin
         rd_valid <= rd_done && final_q;
         if (rd_done && final_q) rd_word <= ext;
      end
   end
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
   parameter int QUIET_CYC = 400
) (
   input logic clk,
   input logic rst_n,
   input logic adc_conv_n,
   input logic adc_sclk,
   input logic adc_cs_n,
   input logic adc_busy_n,
   input logic rd_valid
);
   logic        conv_q, armed, seen_low;
   logic [31:0] wc;
   logic        in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q   <= 1'b1;
         armed    <= 1'b0;
         seen_low <= 1'b0;
         wc       <= '0;
      end else begin
         conv_q <= adc_conv_n;
         if (conv_q && !adc_conv_n) begin
            armed    <= 1'b1;
            seen_low <= 1'b0;
            wc       <= 32'd1;
         end else if (armed) begin
            if (wc != '1) wc <= wc + 1'b1;
            if (!adc_busy_n) seen_low <= 1'b1;
            else if (seen_low) armed <= 1'b0;
         end
      end
   end

   assign in_win = armed && seen_low && !adc_busy_n && (wc > 32'(QUIET_CYC));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> ($stable(adc_conv_n) && $stable(adc_sclk) && $stable(adc_cs_n)));
   assert_sclk_low_at_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_busy_n) |-> !adc_sclk);
   assert_sel_with_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_sclk |-> !adc_cs_n);
   assert_conv_reader_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_n) |-> adc_cs_n);
   assert_conv_min_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_n) |=> !adc_conv_n);
   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> adc_cs_n);
endmodule

bind adc_read_sequencer srd_checker #(.QUIET_CYC(QUIET_CYC)) u_srd_checker (
   .clk(clk), .rst_n(rst_n), .adc_conv_n(adc_conv_n), .adc_sclk(adc_sclk),
   .adc_cs_n(adc_cs_n), .adc_busy_n(adc_busy_n), .rd_valid(rd_valid)
);

// File: tb/tb_adc_read_sequencer.sv
`timescale 1ns/1ps
module tb_adc_read_sequencer;
   localparam int BUSY_DLY = 5;
   localparam int BUSY_LEN = 900;
   localparam int QUIET    = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0;
   logic [15:0] period_cyc = 16'd0;
   logic [7:0]  sclk_half = 8'd5;
   logic [1:0]  strategy = 2'b00;
   logic adc_busy_n;
   logic adc_sdata;
   logic adc_conv_n, adc_sclk, adc_cs_n, rd_valid, early_slow;
   logic [15:0] rd_word;

   always #10 clk = ~clk;

   adc_read_sequencer dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_cyc(period_cyc),
      .sclk_half(sclk_half), .strategy(strategy), .adc_busy_n(adc_busy_n),
      .adc_sdata(adc_sdata), .adc_conv_n(adc_conv_n), .adc_sclk(adc_sclk),
      .adc_cs_n(adc_cs_n), .rd_word(rd_word), .rd_valid(rd_valid),
      .early_slow(early_slow)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   function automatic logic [11:0] val(input int k);
      if (k == 0) return 12'h7FF;
      if (k == 1) return 12'h800;
      return 12'((k * 32'h9E3 + 32'h123) & 32'hFFF);
   endfunction

   function automatic logic [15:0] sx(input logic [11:0] v);
      return {{4{v[11]}}, v};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // converter model
   int   cidx = 0;
   int   lost = 0;
   int   quiet_viol = 0;
   logic conv_p = 1'b1, sclk_p = 1'b0, cs_p = 1'b1;
   int   bcnt = 0;
   bit   active = 1'b0;
   int   qc = 0;
   logic [11:0] shreg = '0;
   int   sc = 12;

   always @(posedge clk) begin
      conv_p <= adc_conv_n;
      sclk_p <= adc_sclk;
      cs_p   <= adc_cs_n;
      if (!rst_n) begin
         adc_busy_n <= 1'b1;
         adc_sdata  <= 1'b0;
         active     <= 1'b0;
      end else begin
         if (conv_p && !adc_conv_n && !active) begin
            active <= 1'b1;
            bcnt   <= 0;
            qc     <= 1;
         end else if (active) begin
            bcnt <= bcnt + 1;
            qc   <= qc + 1;
            if (bcnt == BUSY_DLY) adc_busy_n <= 1'b0;
            if (bcnt > BUSY_DLY && qc > QUIET &&
                (adc_conv_n != conv_p || adc_sclk != sclk_p || adc_cs_n != cs_p))
               quiet_viol <= quiet_viol + 1;
            if (bcnt == BUSY_DLY + BUSY_LEN) begin
               adc_busy_n <= 1'b1;
               active     <= 1'b0;
               if (adc_sclk && !adc_cs_n) lost <= lost + 1;
               else begin
                  shreg     <= val(cidx);
                  sc        <= 0;
                  adc_sdata <= 1'b0;
               end
               cidx <= cidx + 1;
            end
         end
         if (adc_sclk && !sclk_p && !adc_cs_n) begin
            if (sc < 12) begin
               adc_sdata <= shreg[11 - sc];
               sc <= sc + 1;
            end else adc_sdata <= 1'b0;
         end
      end
   end

   // output monitor
   bit   clr_mon = 1'b0;
   int   cyc = 0;
   int   nconv = 0;
   int   conv_t[0:63];
   logic [15:0] words[0:63];
   int   nwords = 0;
   int   cur_hi = 0, last_hi = 0, cur_lo = 0, last_lo = 0;
   bit   slow_seen = 1'b0;
   logic mconv_p = 1'b1;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      mconv_p <= adc_conv_n;
      if (clr_mon) begin
         nconv <= 0; nwords <= 0; slow_seen <= 1'b0;
      end else begin
         if (mconv_p && !adc_conv_n && nconv < 64) begin
            conv_t[nconv] <= cyc;
            nconv <= nconv + 1;
         end
         if (rd_valid && nwords < 64) begin
            words[nwords] <= rd_word;
            nwords <= nwords + 1;
         end
         if (early_slow) slow_seen <= 1'b1;
      end
      if (adc_sclk) cur_hi <= cur_hi + 1;
      else if (cur_hi != 0) begin last_hi <= cur_hi; cur_hi <= 0; end
      if (!adc_conv_n) cur_lo <= cur_lo + 1;
      else if (cur_lo != 0) begin last_lo <= cur_lo; cur_lo <= 0; end
   end

   task automatic check_reset();
      @(negedge clk);
      chk(adc_conv_n == 1'b1, "R1", "conv_n", adc_conv_n, 1);
      chk(adc_sclk == 1'b0, "R1", "sclk", adc_sclk, 0);
      chk(adc_cs_n == 1'b1, "R1", "cs_n", adc_cs_n, 1);
      chk(rd_valid == 1'b0, "R1", "valid", rd_valid, 0);
      chk(rd_word == 16'h0, "R1", "word", rd_word, 0);
      chk(early_slow == 1'b0, "R1", "flag", early_slow, 0);
      repeat (50) @(negedge clk);
      chk(nconv == 0, "R11", "conv while disabled", nconv, 0);
   endtask

   task automatic run_mode(input logic [1:0] strat, input int half, input int rate,
                           input int n, input bit exp_slow, input int exp_hi,
                           input int exp_space, input string req);
      int base, nexp, guard;
      @(negedge clk);
      strategy = strat; sclk_half = 8'(half); period_cyc = 16'(rate);
      clr_mon = 1'b1;
      @(negedge clk);
      clr_mon = 1'b0;
      base = cidx;
      run_en = 1'b1;
      guard = 0;
      while (nconv < n && guard < 40000) begin @(negedge clk); guard++; end
      run_en = 1'b0;
      repeat (3000) @(negedge clk);
      nexp = ((strat == 2'b01 || strat == 2'b10) && !exp_slow) ? n - 1 : n;
      chk(nconv == n, "R11", "conversions after disable", nconv, n);
      chk(nwords == nexp, req, "word count", nwords, nexp);
      for (int i = 0; i < nexp && i < nwords; i++)
         chk(words[i] == sx(val(base + i)), "R5", "word value", words[i], sx(val(base + i)));
      chk(slow_seen == exp_slow, "R10", "early_slow", slow_seen, exp_slow);
      chk(quiet_viol == 0, "R9", "quiet window changes", quiet_viol, 0);
      chk(lost == 0, "R9", "results lost", lost, 0);
      chk(last_hi == exp_hi, "R4", "sclk high width", last_hi, exp_hi);
      chk(last_lo == 3, "R2", "convert low width", last_lo, 3);
      if (exp_space != 0)
         chk(conv_t[1] - conv_t[0] == exp_space, "R3", "convert spacing",
             conv_t[1] - conv_t[0], exp_space);
      chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R4", "idle lines",
          {adc_cs_n, adc_sclk}, 2);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_reset();
      run_mode(2'b00, 5, 10, 4, 1'b0, 5, 1250, "R6");
      run_mode(2'b11, 1, 1600, 3, 1'b0, 3, 1600, "R6");
      run_mode(2'b01, 5, 0, 4, 1'b0, 5, 1250, "R7");
      run_mode(2'b10, 6, 0, 4, 1'b0, 6, 1250, "R8");
      run_mode(2'b01, 30, 0, 3, 1'b1, 30, 0, "R10");
      run_mode(2'b10, 45, 0, 3, 1'b1, 45, 0, "R10");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule